// File: doc/BRIEF.md
# Parallel NFA State Transition Row

This block evaluates a nondeterministic finite automaton over a stream of 8-bit symbols. The automaton is held as a row of sixteen programmable state elements. Each symbol is broadcast to every element in the same cycle. An element fires when it is currently enabled and the symbol is a member of its own 256-entry acceptance set. The set of elements that fire then decides which elements are enabled for the next symbol. Each element chooses, through a 16-bit select, which firing elements wake it up, and it may choose itself. There is no single state register, so any number of elements can be live at the same moment.

Software fills the row through a write port while no stream is running. A write sets one 32-bit slice of an element's acceptance set, its wake-up select, or its mode bits. A pulse on `streamStart` clears all live state and opens a stream. Symbols are then presented with a valid strobe, one per cycle. A pulse on `streamStop` closes the stream. For every accepted symbol, the row returns a registered vector of the elements that fired and a vector of the firings that are flagged for reporting.

Top module: `nfa_row`

## Requirements
- R1: After reset, `matchValid`, `matchVec` and `reportVec` are zero, every element is unprogrammed (empty acceptance set, no select, start mode none, no report), and no stream is running.
- R2: A write (`cfgWe` high) changes element `cfgElem` only while no stream is running and `streamStart` is low. Field 0 loads bits `[32*cfgWord+31 : 32*cfgWord]` of the acceptance set from `cfgData`, where bit k of the set accepts symbol value k. Field 1 loads the wake-up select from `cfgData[15:0]`, where bit j means "woken by element j". Field 2 loads the start mode from `cfgData[1:0]` (0 none, 1 first-symbol, 2 every-symbol) and the report flag from `cfgData[2]`. A write made during a stream has no effect.
- R3: For a symbol accepted in cycle t, `matchValid` is high in cycle t+1 and bit i of `matchVec` equals (element i effectively live) AND (acceptance bit `symbol` of element i).
- R4: After an accepted symbol, the stored live bit of element i becomes the OR over j of (element j fired AND select bit j of element i). An element whose select holds its own bit keeps itself live across a run of accepted symbols.
- R5: An element in every-symbol mode is effectively live on every accepted symbol, whatever its stored live bit.
- R6: An element in first-symbol mode is effectively live on the first symbol accepted after `streamStart` and, unless it is woken by the select, on no later symbol.
- R7: `reportVec` bit i is high exactly when `matchVec` bit i is high and element i has its report flag set.
- R8: In a cycle with `symValid` low, the live bits and the first-symbol condition are unchanged, and in the next cycle `matchValid`, `matchVec` and `reportVec` are zero.
- R9: `streamStart` clears every live bit, re-arms first-symbol mode and opens a stream. A symbol presented in the same cycle as `streamStart` is ignored.
- R10: `streamStop` closes the stream. Symbols presented outside a stream produce no `matchValid`, and configuration writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgElem | input | 4 | Element index of the write |
| cfgField | input | 2 | Field: 0 mask slice, 1 wake-up select, 2 mode |
| cfgWord | input | 3 | Acceptance-set slice index for field 0 |
| cfgData | input | 32 | Write data |
| streamStart | input | 1 | Opens a stream and clears live state |
| streamStop | input | 1 | Closes the stream |
| symValid | input | 1 | Symbol strobe |
| symbol | input | 8 | Broadcast symbol |
| matchValid | output | 1 | Result of the previous cycle's symbol is present |
| matchVec | output | 16 | Elements that fired |
| reportVec | output | 16 | Fired elements with report enabled |

## Verification
The assertions assume three things about the inputs: `streamStart` and `streamStop` are never high together, no symbol is presented in the cycle that closes a stream, and each configuration strobe lasts a single cycle. The stimulus keeps within these limits because every task drives exactly one control action per cycle at the falling edge and returns every strobe to zero before the next action. Expected firing and report vectors come from a separate bench model of the live bits. The model is fed the same writes and symbols, and it also applies the write lock and the rule that a start-cycle symbol is dropped.

// File: rtl/nfa_row_pkg.sv
package nfa_row_pkg;

  typedef enum logic [1:0] {
    FLD_MASK = 2'd0,
    FLD_SEL  = 2'd1,
    FLD_MODE = 2'd2
  } cfgField_t;

  typedef enum logic [1:0] {
    START_NONE  = 2'd0,
    START_FIRST = 2'd1,
    START_ALL   = 2'd2
  } startMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgWr;      // accepted configuration write
    logic clrActive;  // stream opening: drop live state
    logic step;       // accepted symbol this cycle
    logic firstSym;   // no symbol accepted yet in this stream
  } rowCtrl_t;

endpackage

// File: rtl/nfa_row_ctrl.sv
module nfa_row_ctrl
  import nfa_row_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWe,
  input  logic     streamStart,
  input  logic     streamStop,
  input  logic     symValid,
  output rowCtrl_t ctrl
);

  logic runQ;
  logic firstQ;
  logic stepS;

  assign stepS = symValid && runQ && !streamStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      firstQ <= 1'b0;
    end else if (streamStart) begin
      runQ   <= 1'b1;
      firstQ <= 1'b1;
    end else begin
      if (streamStop) runQ <= 1'b0;
      if (stepS) firstQ <= 1'b0;
    end
  end

  always_comb begin
    ctrl.cfgWr     = cfgWe && !runQ && !streamStart;
    ctrl.clrActive = streamStart;
    ctrl.step      = stepS;
    ctrl.firstSym  = firstQ;
  end

endmodule

// File: rtl/nfa_row_datapath.sv
module nfa_row_datapath
  import nfa_row_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int SYM_W    = 8,
  parameter int CFG_W    = 32,
  localparam int ALPHA   = 1 << SYM_W,
  localparam int WORDS   = ALPHA / CFG_W,
  localparam int WORD_W  = $clog2(WORDS),
  localparam int ELEM_W  = $clog2(NUM_ELEM)
) (
  input  logic                clk,
  input  logic                rstN,
  input  rowCtrl_t            ctrl,
  input  logic [ELEM_W-1:0]   cfgElem,
  input  logic [1:0]          cfgField,
  input  logic [WORD_W-1:0]   cfgWord,
  input  logic [CFG_W-1:0]    cfgData,
  input  logic [SYM_W-1:0]    symbol,
  output logic                matchValid,
  output logic [NUM_ELEM-1:0] matchVec,
  output logic [NUM_ELEM-1:0] reportVec
);

  logic [NUM_ELEM-1:0] hitS;
  logic [NUM_ELEM-1:0] repEn;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : gElem
    logic [ALPHA-1:0]    maskQ;
    logic [NUM_ELEM-1:0] selQ;
    startMode_t          modeQ;
    logic                repQ;
    logic                actQ;
    logic                wrHere;
    logic                effAct;

    assign wrHere = ctrl.cfgWr && (cfgElem == ELEM_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ <= '0;
        selQ  <= '0;
        modeQ <= START_NONE;
        repQ  <= 1'b0;
      end else if (wrHere) begin
        case (cfgField)
          FLD_MASK: maskQ[cfgWord*CFG_W +: CFG_W] <= cfgData;
          FLD_SEL:  selQ <= cfgData[NUM_ELEM-1:0];
          FLD_MODE: begin
            modeQ <= startMode_t'(cfgData[1:0]);
            repQ  <= cfgData[2];
          end
          default: ;
        endcase
      end
    end

    // Live bit: cleared on stream open, recomputed from routed firings per symbol
    always_ff @(posedge clk) begin
      if (!rstN)               actQ <= 1'b0;
      else if (ctrl.clrActive) actQ <= 1'b0;
      else if (ctrl.step)      actQ <= |(hitS & selQ);
    end

    assign effAct  = actQ || (modeQ == START_ALL) ||
                     ((modeQ == START_FIRST) && ctrl.firstSym);
    assign hitS[e]  = effAct && maskQ[symbol];
    assign repEn[e] = repQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      matchVec   <= '0;
      reportVec  <= '0;
    end else if (ctrl.step) begin
      matchValid <= 1'b1;
      matchVec   <= hitS;
      reportVec  <= hitS & repEn;
    end else begin
      matchValid <= 1'b0;
      matchVec   <= '0;
      reportVec  <= '0;
    end
  end

endmodule

// File: rtl/nfa_row.sv
module nfa_row
  import nfa_row_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int SYM_W    = 8,
  parameter int CFG_W    = 32,
  localparam int WORD_W  = $clog2((1 << SYM_W) / CFG_W),
  localparam int ELEM_W  = $clog2(NUM_ELEM)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [ELEM_W-1:0]   cfgElem,
  input  logic [1:0]          cfgField,
  input  logic [WORD_W-1:0]   cfgWord,
  input  logic [CFG_W-1:0]    cfgData,
  input  logic                streamStart,
  input  logic                streamStop,
  input  logic                symValid,
  input  logic [SYM_W-1:0]    symbol,
  output logic                matchValid,
  output logic [NUM_ELEM-1:0] matchVec,
  output logic [NUM_ELEM-1:0] reportVec
);

  rowCtrl_t ctrlS;

  nfa_row_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .streamStart (streamStart),
    .streamStop  (streamStop),
    .symValid    (symValid),
    .ctrl        (ctrlS)
  );

  nfa_row_datapath #(
    .NUM_ELEM (NUM_ELEM),
    .SYM_W    (SYM_W),
    .CFG_W    (CFG_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlS),
    .cfgElem    (cfgElem),
    .cfgField   (cfgField),
    .cfgWord    (cfgWord),
    .cfgData    (cfgData),
    .symbol     (symbol),
    .matchValid (matchValid),
    .matchVec   (matchVec),
    .reportVec  (reportVec)
  );

endmodule

// File: rtl/nfa_row_chk.sv
module nfa_row_chk #(
  parameter int NUM_ELEM = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                streamStart,
  input logic                streamStop,
  input logic                symValid,
  input logic                cfgWr,
  input logic                matchValid,
  input logic [NUM_ELEM-1:0] matchVec,
  input logic [NUM_ELEM-1:0] reportVec
);

  // Independent view of whether a stream is open, from the top-level pins
  logic shadowRun;
  always_ff @(posedge clk) begin
    if (!rstN)            shadowRun <= 1'b0;
    else if (streamStart) shadowRun <= 1'b1;
    else if (streamStop)  shadowRun <= 1'b0;
  end

  AST_CFG_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |-> !shadowRun); // R2

  AST_RESULT_FOLLOWS_SYMBOL: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> $past(symValid)); // R3

  AST_REPORT_WITHIN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (reportVec & ~matchVec) == '0); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> (!matchValid && matchVec == '0 && reportVec == '0)); // R8

  AST_START_DROPS_SYMBOL: assert property (@(posedge clk) disable iff (!rstN)
    streamStart |=> !matchValid); // R9

  AST_CLOSED_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (!shadowRun && !streamStart) |=> !matchValid); // R10

endmodule

bind nfa_row nfa_row_chk #(.NUM_ELEM(NUM_ELEM)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .streamStart (streamStart),
  .streamStop  (streamStop),
  .symValid    (symValid),
  .cfgWr       (ctrlS.cfgWr),
  .matchValid  (matchValid),
  .matchVec    (matchVec),
  .reportVec   (reportVec)
);

// File: tb/nfa_row_test.sv
module nfa_row_test;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;
  localparam int NE         = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgElem = '0;
  logic [1:0]  cfgField = '0;
  logic [2:0]  cfgWord = '0;
  logic [31:0] cfgData = '0;
  logic        streamStart = 1'b0;
  logic        streamStop = 1'b0;
  logic        symValid = 1'b0;
  logic [7:0]  symbol = '0;
  logic        matchValid;
  logic [15:0] matchVec;
  logic [15:0] reportVec;

  always #(CLK_PERIOD/2) clk = ~clk;

  nfa_row uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgElem(cfgElem),
    .cfgField(cfgField), .cfgWord(cfgWord), .cfgData(cfgData),
    .streamStart(streamStart), .streamStop(streamStop),
    .symValid(symValid), .symbol(symbol), .matchValid(matchValid),
    .matchVec(matchVec), .reportVec(reportVec)
  );

  int testCnt = 0;
  int failCnt = 0;

  typedef struct {
    logic [15:0] hit;
    logic [15:0] rep;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  // Bench model, built from the requirements
  logic [255:0] mMask [NE];
  logic [15:0]  mSel  [NE];
  logic [1:0]   mMode [NE];
  logic [15:0]  mRep;
  logic [15:0]  mAct;
  logic         mFirst;
  logic         mRun;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleDrive();
    cfgWe = 1'b0; streamStart = 1'b0; streamStop = 1'b0; symValid = 1'b0;
  endtask

  task automatic cfgWrite(input int e, input int fld, input int w, input logic [31:0] d);
    @(negedge clk);
    idleDrive();
    cfgWe = 1'b1; cfgElem = 4'(e); cfgField = 2'(fld); cfgWord = 3'(w); cfgData = d;
    if (!mRun) begin
      case (fld)
        0: mMask[e][w*32 +: 32] = d;
        1: mSel[e] = d[15:0];
        2: begin mMode[e] = d[1:0]; mRep[e] = d[2]; end
        default: ;
      endcase
    end
  endtask

  task automatic acceptSym(input int e, input logic [7:0] s);
    logic [255:0] nm;
    nm = mMask[e];
    nm[s] = 1'b1;
    cfgWrite(e, 0, int'(s) / 32, nm[(int'(s)/32)*32 +: 32]);
  endtask

  task automatic startStream(input bit withSym, input logic [7:0] s);
    @(negedge clk);
    idleDrive();
    streamStart = 1'b1;
    symValid = withSym;
    symbol = s;
    mAct = '0; mFirst = 1'b1; mRun = 1'b1;
  endtask

  task automatic stopStream();
    @(negedge clk);
    idleDrive();
    streamStop = 1'b1;
    mRun = 1'b0;
  endtask

  task automatic sendSym(input logic [7:0] s, input string tag);
    logic [15:0] h;
    logic [15:0] nextAct;
    expItem_t it;
    @(negedge clk);
    idleDrive();
    symValid = 1'b1;
    symbol = s;
    if (mRun) begin
      for (int e = 0; e < NE; e++) begin
        logic eff;
        eff = mAct[e] || (mMode[e] == 2'd2) || ((mMode[e] == 2'd1) && mFirst);
        h[e] = eff && mMask[e][s];
      end
      for (int e = 0; e < NE; e++) nextAct[e] = |(h & mSel[e]);
      mAct = nextAct;
      mFirst = 1'b0;
      it.hit = h; it.rep = h & mRep; it.tag = tag;
      expQ.push_back(it);
    end else begin
      @(negedge clk);
      idleDrive();
      check(!matchValid, "R10 symbol outside stream ignored", 32'(matchValid), 0);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    idleDrive();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!matchValid && matchVec == 0 && reportVec == 0,
            "R8 quiet result while no symbol", {matchVec, reportVec}, 0);
    end
  endtask

  // Monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rstN && matchValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected matchValid", 32'(matchVec), 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(matchVec == it.hit, {it.tag, " matchVec (R3 R4)"}, 32'(matchVec), 32'(it.hit));
        check(reportVec == it.rep, {it.tag, " reportVec (R7)"}, 32'(reportVec), 32'(it.rep));
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=finish", WDOG);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    for (int e = 0; e < NE; e++) begin
      mMask[e] = '0; mSel[e] = '0; mMode[e] = '0;
    end
    mRep = '0; mAct = '0; mFirst = 1'b0; mRun = 1'b0;

    repeat (3) @(negedge clk);
    check(!matchValid, "R1 matchValid after reset", 32'(matchValid), 0);
    check(matchVec == 0, "R1 matchVec after reset", 32'(matchVec), 0);
    check(reportVec == 0, "R1 reportVec after reset", 32'(reportVec), 0);
    rstN = 1'b1;

    // Program a(b)+c with report on c, plus an every-symbol 'x' reporter
    acceptSym(0, 8'h61); cfgWrite(0, 2, 0, 32'h1);
    acceptSym(1, 8'h62); cfgWrite(1, 1, 0, 32'h0003);
    acceptSym(2, 8'h63); cfgWrite(2, 1, 0, 32'h0002); cfgWrite(2, 2, 0, 32'h4);
    acceptSym(3, 8'h78); cfgWrite(3, 2, 0, 32'h6);
    acceptSym(4, 8'h00); acceptSym(4, 8'hFF); cfgWrite(4, 2, 0, 32'h2);

    // R1: unprogrammed elements stay silent; R9 opens stream
    startStream(1'b0, 8'h00);
    sendSym(8'h61, "R6 first symbol a");
    sendSym(8'h62, "R4 routed b");
    idle(3);
    sendSym(8'h62, "R4 self loop b after idle R8");
    sendSym(8'h62, "R4 self loop b");
    sendSym(8'h63, "R7 reported c");
    sendSym(8'h78, "R5 every-symbol x");
    sendSym(8'h61, "R6 a not first");
    // Write during stream must be dropped
    acceptSym(3, 8'h79);
    sendSym(8'h79, "R2 locked write had no effect");
    idle(2);

    // R9: symbol in the start cycle is ignored, first-symbol stays armed
    startStream(1'b1, 8'h61);
    sendSym(8'h61, "R9 start-cycle symbol dropped");
    sendSym(8'h62, "R9 live state rebuilt");
    startStream(1'b0, 8'h00);
    sendSym(8'h62, "R9 live bits cleared");
    idle(1);

    // R10: close, symbol ignored, write accepted again
    stopStream();
    sendSym(8'h78, "R10");
    acceptSym(3, 8'h79);
    startStream(1'b0, 8'h00);
    sendSym(8'h79, "R2 write after stop accepted");
    sendSym(8'h00, "R2 lowest slice bit 0");
    sendSym(8'hFF, "R2 highest slice bit 31");
    sendSym(8'h7F, "R5 no element accepts");
    idle(2);
    check(expQ.size() == 0, "R3 every result delivered", expQ.size(), 0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule